// File: doc/BRIEF.md
# Calendar Clock with Time-of-Day Alarm

The block keeps wall-clock time in seven byte-wide count registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Software reaches them, three alarm bytes, two control bytes and one status byte through a plain register port with a 4-bit address and 8-bit data. A one-cycle `tick` pulse, normally once per second, advances the time by one second. Carries ripple through all fields in a single update, covering month lengths and leap years.

A control bit picks how every count and alarm byte is held: packed BCD or plain binary. A second control bit picks 12-hour or 24-hour hours. The stored bytes always stay in the chosen encoding, and the alarm comparison works directly on them. Before loading a new time, software raises a freeze bit so that no tick can overwrite its writes. It can also watch an update-busy flag. After each update the block raises an update-done event, and an alarm event when the new seconds, minutes and hours equal the alarm bytes. Either event can drive the active-high `irq` output, each through its own enable bit.

Top module: `calclk`

## Requirements
- R1: Register addresses are: 0x0 seconds, 0x1 seconds alarm, 0x2 minutes, 0x3 minutes alarm, 0x4 hours, 0x5 hours alarm, 0x6 day of week, 0x7 day of month, 0x8 month, 0x9 year, 0xA control A, 0xB control B, 0xC status. Count, alarm and control B bytes read back as written. The status byte ignores writes.
- R2: With control B bit 7 clear, a `tick` sampled high sets control A bit 7 (busy) in the next cycle. In the cycle after that, busy is clear and the time has advanced by one second.
- R3: While control B bit 7 is set, a tick is dropped. Busy stays 0, the count bytes keep their values, and no status flag is raised.
- R4: With control B bit 2 = 1 (binary), every field holds its plain binary value. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0 in 24-hour mode, with a carry into the next field each time.
- R5: With control B bit 2 = 0, every count and alarm byte holds two BCD digits, tens in bits 7:4 and units in bits 3:0. Advances produce valid BCD.
- R6: With control B bit 1 = 0 (12-hour), hours bit 7 is the PM flag and the hour runs 12, 1, ..., 11. 11 AM advances to 12 PM, 11 PM advances to 12 AM of the next day, and 12 PM advances to 1 PM. With bit 1 = 1, hours run 0 to 23.
- R7: At a day carry, day of week steps 1 to 7 and wraps to 1. Day of month wraps to 1 after 30 for April, June, September and November, after 31 for the other long months, and after 28 for February (29 when the year is divisible by four). Month wraps from 12 to 1 and year from 99 to 0.
- R8: Every completed update sets status bit 4. Status bit 5 is also set when the updated seconds, minutes and hours bytes equal the three alarm bytes exactly.
- R9: Status bit 7 equals (bit 5 AND control B bit 5) OR (bit 4 AND control B bit 4), and `irq` equals bit 7. Reading the status byte returns the flags and clears them in the same access.
- R10: After reset, control B reads 0x80 (frozen, BCD, 12-hour, interrupts off). All other registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse requesting a one-second advance |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; qualifies the clear-on-read of the status byte |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Active-high interrupt request (status bit 7) |

## Verification
The assertions take for granted that `tick` arrives at most once every two cycles. A tick that lands while busy is high is simply absorbed. They also assume software does not write the seconds byte during an update. The directed tests follow both rules: each advance is a single pulse followed by idle cycles, and all time loads happen with the freeze bit set, before it is released. The bench loads only legal field values, so each expected rollover is fixed by the calendar rules alone.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NF     = 7;   // count fields
  localparam int unsigned NA     = 3;   // alarm fields

  // field indices
  localparam int unsigned F_SEC = 0;
  localparam int unsigned F_MIN = 1;
  localparam int unsigned F_HR  = 2;
  localparam int unsigned F_DOW = 3;
  localparam int unsigned F_DOM = 4;
  localparam int unsigned F_MON = 5;
  localparam int unsigned F_YR  = 6;

  localparam logic [ADDR_W-1:0] A_CTLA = 4'hA;
  localparam logic [ADDR_W-1:0] A_CTLB = 4'hB;
  localparam logic [ADDR_W-1:0] A_STAT = 4'hC;

  typedef logic [6:0] val_t;

  function automatic logic [ADDR_W-1:0] field_addr(input int unsigned i);
    case (i)
      F_SEC:   return 4'h0;
      F_MIN:   return 4'h2;
      F_HR:    return 4'h4;
      F_DOW:   return 4'h6;
      F_DOM:   return 4'h7;
      F_MON:   return 4'h8;
      default: return 4'h9;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] alarm_addr(input int unsigned i);
    case (i)
      0:       return 4'h1;
      1:       return 4'h3;
      default: return 4'h5;
    endcase
  endfunction

  function automatic val_t dec_byte(input logic [7:0] b, input logic bin);
    logic [7:0] t;
    if (bin) t = b;
    else     t = ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    return t[6:0];
  endfunction

  function automatic logic [7:0] enc_byte(input val_t v, input logic bin);
    logic [7:0] w, tens, ones;
    w    = {1'b0, v};
    tens = w / 8'd10;
    ones = w - tens * 8'd10;
    if (bin) return w;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic val_t dec_hour(input logic [7:0] b, input logic bin, input logic h24);
    val_t h;
    h = dec_byte({1'b0, b[6:0]}, bin);
    if (!h24) begin
      if (h == 7'd12) h = 7'd0;
      if (b[7])       h = h + 7'd12;
    end
    return h;
  endfunction

  function automatic logic [7:0] enc_hour(input val_t v, input logic bin, input logic h24);
    logic       pm;
    val_t       h12;
    logic [7:0] t;
    if (h24) return enc_byte(v, bin);
    pm  = (v >= 7'd12);
    h12 = pm ? v - 7'd12 : v;
    if (h12 == 7'd0) h12 = 7'd12;
    t = enc_byte(h12, bin);
    return {pm, t[6:0]};
  endfunction

endpackage

// File: rtl/calclk_decode.sv
module calclk_decode
  import calclk_pkg::*;
#(
  parameter int unsigned N = NF
) (
  input  logic [N-1:0][7:0] raw,
  input  logic              bin,
  input  logic              h24,
  output logic [N-1:0][6:0] val
);
  for (genvar i = 0; i < N; i++) begin : g_fld
    if (i == F_HR) begin : g_hour
      assign val[i] = dec_hour(raw[i], bin, h24);
    end else begin : g_plain
      assign val[i] = dec_byte(raw[i], bin);
    end
  end
endmodule

// File: rtl/calclk_encode.sv
module calclk_encode
  import calclk_pkg::*;
#(
  parameter int unsigned N = NF
) (
  input  logic [N-1:0][6:0] val,
  input  logic              bin,
  input  logic              h24,
  output logic [N-1:0][7:0] raw
);
  for (genvar i = 0; i < N; i++) begin : g_fld
    if (i == F_HR) begin : g_hour
      assign raw[i] = enc_hour(val[i], bin, h24);
    end else begin : g_plain
      assign raw[i] = enc_byte(val[i], bin);
    end
  end
endmodule

// File: rtl/calclk_step.sv
module calclk_step
  import calclk_pkg::*;
#(
  parameter int unsigned YEAR_LAST  = 99,
  parameter int unsigned LEAP_EVERY = 4,
  parameter int unsigned DOW_LAST   = 7
) (
  input  logic [NF-1:0][6:0] cur,
  output logic [NF-1:0][6:0] nxt
);
  localparam val_t YL = val_t'(YEAR_LAST);
  localparam val_t LP = val_t'(LEAP_EVERY);
  localparam val_t DL = val_t'(DOW_LAST);

  logic c_sec, c_min, c_hr, c_day, c_mon;
  val_t dim;

  always_comb begin
    case (cur[F_MON])
      7'd2:                      dim = ((cur[F_YR] % LP) == 7'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase

    c_sec = (cur[F_SEC] >= 7'd59);
    c_min = c_sec && (cur[F_MIN] >= 7'd59);
    c_hr  = c_min && (cur[F_HR]  >= 7'd23);
    c_day = c_hr  && (cur[F_DOM] >= dim);
    c_mon = c_day && (cur[F_MON] >= 7'd12);

    nxt = cur;
    nxt[F_SEC] = c_sec ? 7'd0 : cur[F_SEC] + 7'd1;
    if (c_sec) nxt[F_MIN] = (cur[F_MIN] >= 7'd59) ? 7'd0 : cur[F_MIN] + 7'd1;
    if (c_min) nxt[F_HR]  = (cur[F_HR]  >= 7'd23) ? 7'd0 : cur[F_HR]  + 7'd1;
    if (c_hr) begin
      nxt[F_DOW] = (cur[F_DOW] >= DL)  ? 7'd1 : cur[F_DOW] + 7'd1;
      nxt[F_DOM] = (cur[F_DOM] >= dim) ? 7'd1 : cur[F_DOM] + 7'd1;
    end
    if (c_day) nxt[F_MON] = (cur[F_MON] >= 7'd12) ? 7'd1 : cur[F_MON] + 7'd1;
    if (c_mon) nxt[F_YR]  = (cur[F_YR]  >= YL)    ? 7'd0 : cur[F_YR]  + 7'd1;
  end
endmodule

// File: rtl/calclk_alarm.sv
module calclk_alarm
  import calclk_pkg::*;
(
  input  logic [NA-1:0][7:0] cand,
  input  logic [NA-1:0][7:0] alarm,
  output logic               hit
);
  logic [NA-1:0] eq;
  for (genvar i = 0; i < NA; i++) begin : g_cmp
    assign eq[i] = (cand[i] == alarm[i]);
  end
  assign hit = &eq;
endmodule

// File: rtl/calclk.sv
module calclk
  import calclk_pkg::*;
#(
  parameter int unsigned YEAR_LAST  = 99,
  parameter int unsigned LEAP_EVERY = 4,
  parameter int unsigned DOW_LAST   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam logic [7:0] CTLB_RST = 8'h80;

  // reset synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // state
  logic [NF-1:0][7:0] cnt_q,   cnt_d;
  logic [NA-1:0][7:0] alm_q,   alm_d;
  logic [6:0]         ctla_q,  ctla_d;
  logic [7:0]         ctlb_q,  ctlb_d;
  logic               af_q, af_d, uf_q, uf_d;
  logic               pend_q, pend_d;

  logic               frz, bin, h24, aie, uie;
  assign frz = ctlb_q[7];
  assign aie = ctlb_q[5];
  assign uie = ctlb_q[4];
  assign bin = ctlb_q[2];
  assign h24 = ctlb_q[1];

  // datapath
  logic [NF-1:0][6:0] cur_v, nxt_v;
  logic [NF-1:0][7:0] nxt_raw;
  logic               alarm_hit;

  calclk_decode #(.N(NF)) u_dec (
    .raw(cnt_q), .bin(bin), .h24(h24), .val(cur_v)
  );

  calclk_step #(
    .YEAR_LAST(YEAR_LAST), .LEAP_EVERY(LEAP_EVERY), .DOW_LAST(DOW_LAST)
  ) u_step (
    .cur(cur_v), .nxt(nxt_v)
  );

  calclk_encode #(.N(NF)) u_enc (
    .val(nxt_v), .bin(bin), .h24(h24), .raw(nxt_raw)
  );

  calclk_alarm u_alarm (
    .cand({nxt_raw[F_HR], nxt_raw[F_MIN], nxt_raw[F_SEC]}),
    .alarm(alm_q),
    .hit(alarm_hit)
  );

  logic stat_rd;
  logic irq_flag;
  assign stat_rd  = rd_en && (addr == A_STAT);
  assign irq_flag = (af_q && aie) || (uf_q && uie);

  // next state
  always_comb begin
    pend_d = tick && !frz && !pend_q;

    for (int i = 0; i < NF; i++) begin
      cnt_d[i] = cnt_q[i];
      if (pend_q) cnt_d[i] = nxt_raw[i];
      if (wr_en && (addr == field_addr(i))) cnt_d[i] = wdata;
    end

    for (int i = 0; i < NA; i++) begin
      alm_d[i] = alm_q[i];
      if (wr_en && (addr == alarm_addr(i))) alm_d[i] = wdata;
    end

    ctla_d = (wr_en && addr == A_CTLA) ? wdata[6:0] : ctla_q;
    ctlb_d = (wr_en && addr == A_CTLB) ? wdata      : ctlb_q;

    af_d = stat_rd ? 1'b0 : af_q;
    uf_d = stat_rd ? 1'b0 : uf_q;
    if (pend_q) begin
      uf_d = 1'b1;
      if (alarm_hit) af_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      alm_q  <= '0;
      ctla_q <= '0;
      ctlb_q <= CTLB_RST;
      af_q   <= 1'b0;
      uf_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      alm_q  <= alm_d;
      ctla_q <= ctla_d;
      ctlb_q <= ctlb_d;
      af_q   <= af_d;
      uf_q   <= uf_d;
      pend_q <= pend_d;
    end
  end

  // read mux
  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NF; i++)
      if (addr == field_addr(i)) rdata = cnt_q[i];
    for (int i = 0; i < NA; i++)
      if (addr == alarm_addr(i)) rdata = alm_q[i];
    if (addr == A_CTLA) rdata = {pend_q, ctla_q};
    if (addr == A_CTLB) rdata = ctlb_q;
    if (addr == A_STAT) rdata = {irq_flag, 1'b0, af_q, uf_q, 4'h0};
  end

  assign irq = irq_flag;

endmodule

// File: rtl/calclk_sva.sv
module calclk_sva
  import calclk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              frz,
  input logic              busy,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        sec_byte,
  input logic              uf,
  input logic              irq
);
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R2

  AST_TICK_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frz && !busy) |=> busy); // R2

  AST_FREEZE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !busy) |=> !busy); // R3

  AST_SEC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(wr_en && addr == 4'h0)) |=> $stable(sec_byte)); // R3

  AST_UPDATE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> uf); // R8

  AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT && !busy) |=> !irq); // R9
endmodule

bind calclk calclk_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .frz      (ctlb_q[7]),
  .busy     (pend_q),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .sec_byte (cnt_q[0]),
  .uf       (uf_q),
  .irq      (irq)
);

// File: tb/calclk_bench.sv
`timescale 1ns/1ps
module calclk_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  calclk u_calclk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // peek without a read strobe (no side effect)
  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic load(input logic [7:0] ctlb, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dm,
                      input logic [7:0] mo, input logic [7:0] y);
    logic [7:0] junk;
    wr(4'hB, ctlb | 8'h80);
    wr(4'h0, s); wr(4'h2, m); wr(4'h4, h);
    wr(4'h6, dw); wr(4'h7, dm); wr(4'h8, mo); wr(4'h9, y);
    wr(4'hB, ctlb & 8'h7F);
    rd(4'hC, junk);
  endtask

  // tick with busy-flag checks
  task automatic do_tick(input string tag);
    logic [7:0] v;
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
    @(negedge clk); peek(4'hA, v);
    chk({tag, " R2 busy high"}, v & 8'h80, 8'h80);
    @(negedge clk); peek(4'hA, v);
    chk({tag, " R2 busy low"}, v & 8'h80, 8'h00);
  endtask

  task automatic expect_time(input string tag, input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dm,
                             input logic [7:0] mo, input logic [7:0] y);
    logic [7:0] v;
    rd(4'h0, v); chk({tag, " sec"}, v, s);
    rd(4'h2, v); chk({tag, " min"}, v, m);
    rd(4'h4, v); chk({tag, " hour"}, v, h);
    rd(4'h6, v); chk({tag, " dow"}, v, dw);
    rd(4'h7, v); chk({tag, " dom"}, v, dm);
    rd(4'h8, v); chk({tag, " month"}, v, mo);
    rd(4'h9, v); chk({tag, " year"}, v, y);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'hB, v); chk("R10 ctlB", v, 8'h80);
    rd(4'h0, v); chk("R10 sec", v, 8'h00);
    rd(4'h5, v); chk("R10 hour alarm", v, 8'h00);
    rd(4'hA, v); chk("R10 ctlA", v, 8'h00);
    rd(4'hC, v); chk("R10 status", v, 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(4'h1, 8'h12); wr(4'h3, 8'h34); wr(4'h5, 8'h56); wr(4'h8, 8'h07);
    rd(4'h1, v); chk("R1 sec alarm", v, 8'h12);
    rd(4'h3, v); chk("R1 min alarm", v, 8'h34);
    rd(4'h5, v); chk("R1 hour alarm", v, 8'h56);
    rd(4'h8, v); chk("R1 month", v, 8'h07);
    wr(4'hC, 8'hFF);
    @(negedge clk);
    chk("R1 status write irq", {7'd0, irq}, 8'h00);
    rd(4'hC, v); chk("R1 status ignores write", v, 8'h00);
  endtask

  task automatic t_binary_leap;
    logic [7:0] v;
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd7, 8'd28, 8'd2, 8'd4);
    do_tick("R4 bin");
    expect_time("R4 R7 leap", 8'd0, 8'd0, 8'd0, 8'd1, 8'd29, 8'd2, 8'd4);
    rd(4'hC, v); chk("R8 uf only", v, 8'h10);
    rd(4'hC, v); chk("R9 cleared", v, 8'h00);
  endtask

  task automatic t_bcd_12h;
    logic [7:0] v;
    load(8'h00, 8'h59, 8'h59, 8'h91, 8'h03, 8'h31, 8'h12, 8'h99);
    do_tick("R5 bcd");
    expect_time("R5 R6 R7 new year", 8'h00, 8'h00, 8'h12, 8'h04, 8'h01, 8'h01, 8'h00);
    load(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h15, 8'h06, 8'h21);
    do_tick("R6 am");
    rd(4'h4, v); chk("R6 11AM to 12PM", v, 8'h92);
    rd(4'h7, v); chk("R6 same day", v, 8'h15);
    load(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h15, 8'h06, 8'h21);
    do_tick("R6 pm");
    rd(4'h4, v); chk("R6 12PM to 1PM", v, 8'h81);
    load(8'h00, 8'h09, 8'h00, 8'h01, 8'h02, 8'h15, 8'h06, 8'h21);
    do_tick("R5 digit");
    rd(4'h0, v); chk("R5 09 to 10", v, 8'h10);
  endtask

  task automatic t_month_ends;
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd3);
    do_tick("R7 feb");
    expect_time("R7 non-leap feb", 8'd0, 8'd0, 8'd0, 8'd4, 8'd1, 8'd3, 8'd3);
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd5, 8'd30, 8'd4, 8'd10);
    do_tick("R7 apr");
    expect_time("R7 april end", 8'd0, 8'd0, 8'd0, 8'd6, 8'd1, 8'd5, 8'd10);
    load(8'h06, 8'd10, 8'd5, 8'd8, 8'd5, 8'd30, 8'd4, 8'd10);
    do_tick("R4 plain");
    expect_time("R4 no carry", 8'd11, 8'd5, 8'd8, 8'd5, 8'd30, 8'd4, 8'd10);
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    wr(4'h1, 8'd30); wr(4'h3, 8'd20); wr(4'h5, 8'd10);
    load(8'h26, 8'd29, 8'd20, 8'd10, 8'd1, 8'd1, 8'd1, 8'd1);
    do_tick("R8 alarm");
    @(negedge clk);
    chk("R9 irq on alarm", {7'd0, irq}, 8'h01);
    rd(4'hC, v); chk("R8 R9 alarm status", v, 8'hB0);
    @(negedge clk);
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);
    rd(4'hC, v); chk("R9 status clear", v, 8'h00);
    do_tick("R8 nomatch");
    rd(4'hC, v); chk("R8 no alarm", v, 8'h10);
  endtask

  task automatic t_update_irq;
    logic [7:0] v;
    load(8'h16, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd1);
    do_tick("R9 uie");
    @(negedge clk);
    chk("R9 irq on update", {7'd0, irq}, 8'h01);
    rd(4'hC, v); chk("R9 update status", v, 8'h90);
  endtask

  task automatic t_freeze;
    logic [7:0] v;
    load(8'h16, 8'd40, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd1);
    wr(4'hB, 8'h96);
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
    @(negedge clk); peek(4'hA, v);
    chk("R3 busy stays low", v & 8'h80, 8'h00);
    repeat (2) @(negedge clk);
    chk("R3 no irq", {7'd0, irq}, 8'h00);
    rd(4'h0, v); chk("R3 sec held", v, 8'd40);
    rd(4'hC, v); chk("R3 no flags", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_binary_leap();
    t_bcd_12h();
    t_month_ends();
    t_alarm();
    t_update_irq();
    t_freeze();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule